// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block supplies the address sequence for a four-beat burst into a synchronous memory. Either of two start strobes, one for the processor side and one for the cache-controller side, captures an external address and opens a burst. From then on an advance input steps a two-bit beat counter. The counter value, folded into the captured low address bits, replaces those two bits on the output while the upper bits stay as loaded.

A select input chooses between two beat orders. In linear order the low bits count upward from the start value and wrap within the aligned group of four. In interleaved order the low bits are the start value XOR the beat count. A second select input sets how many cycles the outputs lag. In flow-through mode the new address appears in the cycle after the edge that loads or advances it. In pipelined mode it appears one cycle later than that, which matches the extra first-beat clock of a pipelined memory.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `burstAddr` is 0, `beatIdx` is 0, `lastBeat` is 0 and `burstActive` is 0.
- R2: When `procStrobe` is high at a rising edge, the block captures `addrIn`, sets the beat count to 0 and raises the active flag.
- R3: `ctrlStrobe` loads a burst exactly as `procStrobe` does. Both strobes high together give a single load.
- R4: When `advance` is high at an edge with a burst active and no strobe, the beat count rises by one, modulo 4.
- R5: When no burst has been loaded since reset, `advance` has no effect: `beatIdx` stays 0 and `burstActive` stays 0.
- R6: With `linearOrder` = 1, `burstAddr[1:0]` equals (start low bits + beat count) mod 4.
- R7: With `linearOrder` = 0, `burstAddr[1:0]` equals the start low bits XOR the beat count.
- R8: After four advances the address is back at its start value. Bits above bit 1 never change except on a load.
- R9: A strobe during a burst reloads the address and clears the beat count, even when `advance` is high in the same cycle.
- R10: With `pipeMode` = 0, the outputs reflect a load or advance in the cycle right after its edge. With `pipeMode` = 1, every output equals the value the flow-through outputs had one cycle earlier.
- R11: `lastBeat` is high exactly when the presented `beatIdx` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| procStrobe | input | 1 | Processor-side burst start |
| ctrlStrobe | input | 1 | Controller-side burst start |
| advance | input | 1 | Step to the next beat |
| linearOrder | input | 1 | 1 = linear wrap order, 0 = XOR interleaved order |
| pipeMode | input | 1 | 1 = one extra output stage, 0 = flow-through |
| addrIn | input | ADDR_W | External start address |
| burstAddr | output | ADDR_W | Current beat address |
| beatIdx | output | 2 | Current beat number within the burst |
| lastBeat | output | 1 | High on beat 3 |
| burstActive | output | 1 | A burst has been loaded since reset |

## Verification
A corrupted beat counter shows on `beatIdx` and on the low two address bits one cycle after the advance that produced it, or two cycles later in pipelined mode. A wrong capture shows in the upper address bits on the first beat after the load. The reference model is updated at every edge and compared at every falling edge, so any divergence is reported in the cycle it first reaches the ports. Bursts run in both orders, start from every low-bit value and wrap past four beats, with reloads arriving together with advances.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } bag_ctrl_t;

  localparam int BEAT_W = 2;
endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      procStrobe,
  input  logic      ctrlStrobe,
  input  logic      advance,
  output bag_ctrl_t ctrlOut,
  output logic      activeQ
);
  logic loadReq;

  assign loadReq = procStrobe | ctrlStrobe;

  always_comb begin
    ctrlOut.load = loadReq;
    ctrlOut.step = advance & activeQ & ~loadReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) activeQ <= 1'b0;
    else if (loadReq) activeQ <= 1'b1;
  end
endmodule

// File: rtl/bag_datapath.sv
module bag_datapath
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bag_ctrl_t         ctrlIn,
  input  logic              activeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              linearOrder,
  input  logic              pipeMode,
  output logic [ADDR_W-1:0] flowAddr,
  output logic [CNT_W-1:0]  flowBeat,
  output logic              flowActive,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [CNT_W-1:0]  beatIdx,
  output logic              lastBeat,
  output logic              burstActive
);
  localparam int HI_W = ADDR_W - CNT_W;
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  lowBits;
  logic [ADDR_W-1:0] stageAddr;
  logic [CNT_W-1:0]  stageBeat;
  logic              stageActive;

  always_comb begin
    if (linearOrder) lowBits = baseQ[CNT_W-1:0] + cntQ;
    else             lowBits = baseQ[CNT_W-1:0] ^ cntQ;
  end

  assign flowAddr   = {baseQ[ADDR_W-1:CNT_W], lowBits};
  assign flowBeat   = cntQ;
  assign flowActive = activeIn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (ctrlIn.load) begin
      baseQ <= addrIn;
      cntQ  <= '0;
    end else if (ctrlIn.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageAddr   <= '0;
      stageBeat   <= '0;
      stageActive <= 1'b0;
    end else begin
      stageAddr   <= flowAddr;
      stageBeat   <= flowBeat;
      stageActive <= flowActive;
    end
  end

  always_comb begin
    if (pipeMode) begin
      burstAddr   = stageAddr;
      beatIdx     = stageBeat;
      burstActive = stageActive;
    end else begin
      burstAddr   = flowAddr;
      beatIdx     = flowBeat;
      burstActive = flowActive;
    end
    lastBeat = (beatIdx == LAST_BEAT);
  end

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the beat counter width");
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              linearOrder,
  input  logic              pipeMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              lastBeat,
  output logic              burstActive
);
  bag_ctrl_t         ctrlBus;
  logic              activeQ;
  logic [ADDR_W-1:0] flowAddr;
  logic [BEAT_W-1:0] flowBeat;
  logic              flowActive;

  bag_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .ctrlOut    (ctrlBus),
    .activeQ    (activeQ)
  );

  bag_datapath #(.ADDR_W(ADDR_W), .CNT_W(BEAT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrlIn      (ctrlBus),
    .activeIn    (activeQ),
    .addrIn      (addrIn),
    .linearOrder (linearOrder),
    .pipeMode    (pipeMode),
    .flowAddr    (flowAddr),
    .flowBeat    (flowBeat),
    .flowActive  (flowActive),
    .burstAddr   (burstAddr),
    .beatIdx     (beatIdx),
    .lastBeat    (lastBeat),
    .burstActive (burstActive)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              procStrobe,
  input logic              ctrlStrobe,
  input logic              advance,
  input logic              linearOrder,
  input logic              pipeMode,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] flowAddr,
  input logic [1:0]        flowBeat,
  input logic              flowActive,
  input logic [ADDR_W-1:0] burstAddr
);
  logic       anyLoad;
  logic [1:0] beatPlus;
  logic [1:0] lowPlus;

  assign anyLoad  = procStrobe | ctrlStrobe;
  assign beatPlus = flowBeat + 2'd1;
  assign lowPlus  = flowAddr[1:0] + 2'd1;

  // R2 R3: a strobe captures the upper address and restarts the count
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    anyLoad |=> (flowBeat == 2'd0) && flowActive &&
                (flowAddr[ADDR_W-1:2] == $past(addrIn[ADDR_W-1:2])));

  // R4: an accepted advance moves the count by one
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyLoad && advance && flowActive) |=> flowBeat == $past(beatPlus));

  // R5: no burst loaded means advance is ignored
  assert_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyLoad && !flowActive) |=> (flowBeat == 2'd0) && !flowActive);

  // R6: linear order steps the low bits by one
  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyLoad && advance && flowActive && linearOrder) |=>
      (!linearOrder || flowAddr[1:0] == $past(lowPlus)));

  // R8: upper bits move only on a load
  assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !anyLoad |=> $stable(flowAddr[ADDR_W-1:2]));

  // R10: pipelined outputs trail the flow-through value by one cycle
  assert_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pipeMode |-> burstAddr == $past(flowAddr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .procStrobe  (procStrobe),
  .ctrlStrobe  (ctrlStrobe),
  .advance     (advance),
  .linearOrder (linearOrder),
  .pipeMode    (pipeMode),
  .addrIn      (addrIn),
  .flowAddr    (flowAddr),
  .flowBeat    (flowBeat),
  .flowActive  (flowActive),
  .burstAddr   (burstAddr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          procStrobe = 1'b0;
  logic          ctrlStrobe = 1'b0;
  logic          advance = 1'b0;
  logic          linearOrder = 1'b1;
  logic          pipeMode = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] burstAddr;
  logic [1:0]    beatIdx;
  logic          lastBeat;
  logic          burstActive;

  int    nVec = 0;
  int    nBad = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  logic [AW-1:0] mBase = '0;
  int            mCnt = 0;
  bit            mActive = 1'b0;
  logic [AW-1:0] sAddr = '0;
  int            sCnt = 0;
  bit            sActive = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk (clk), .rst_n (rst_n), .procStrobe (procStrobe), .ctrlStrobe (ctrlStrobe),
    .advance (advance), .linearOrder (linearOrder), .pipeMode (pipeMode),
    .addrIn (addrIn), .burstAddr (burstAddr), .beatIdx (beatIdx),
    .lastBeat (lastBeat), .burstActive (burstActive)
  );

  function automatic logic [AW-1:0] modelFlow();
    int lo;
    if (linearOrder) lo = (int'(mBase[1:0]) + mCnt) % 4;
    else             lo = int'(mBase[1:0]) ^ mCnt;
    return {mBase[AW-1:2], 2'(lo)};
  endfunction

  task automatic compareAll();
    logic [AW-1:0] eAddr;
    int eCnt;
    bit eAct;
    if (pipeMode) begin eAddr = sAddr; eCnt = sCnt; eAct = sActive; end
    else begin eAddr = modelFlow(); eCnt = mCnt; eAct = mActive; end
    nVec++;
    if (burstAddr !== eAddr || int'(beatIdx) != eCnt || burstActive !== eAct ||
        lastBeat !== (eCnt == 3)) begin
      nBad++;
      $display("FAIL %s: addr=%h beat=%0d last=%b act=%b expected addr=%h beat=%0d last=%b act=%b",
               curReq, burstAddr, beatIdx, lastBeat, burstActive,
               eAddr, eCnt, (eCnt == 3), eAct);
    end
  endtask

  task automatic tick(input bit ps, input bit cs, input bit adv, input logic [AW-1:0] a);
    procStrobe = ps; ctrlStrobe = cs; advance = adv; addrIn = a;
    @(posedge clk);
    if (!rst_n) begin
      mBase = '0; mCnt = 0; mActive = 0; sAddr = '0; sCnt = 0; sActive = 0;
    end else begin
      sAddr = modelFlow(); sCnt = mCnt; sActive = mActive;
      if (ps || cs) begin mBase = a; mCnt = 0; mActive = 1; end
      else if (adv && mActive) mCnt = (mCnt + 1) % 4;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R1: reset values, then first cycle after release
    curReq = "R1";
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1, 18'h3FFFF);
    rst_n = 1'b1;
    tick(0, 0, 0, '0);
    // R5: advance before any load is ignored
    curReq = "R5";
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 18'h12345);
    // R2 R6 R8 R11: processor load, linear, wrap over six advances
    curReq = "R2_R6_R8_R11";
    linearOrder = 1'b1;
    tick(1, 0, 0, 18'h23456);
    for (int i = 0; i < 6; i++) tick(0, 0, 1, '0);
    tick(0, 0, 0, '0);
    // R3 R7 R8: controller load, interleaved, all start values
    curReq = "R3_R7_R8";
    linearOrder = 1'b0;
    for (int s = 0; s < 4; s++) begin
      tick(0, 1, 0, {16'hA5C3, 2'(s)});
      for (int i = 0; i < 5; i++) tick(0, 0, (i != 2), '0);
    end
    // R6: linear from each start value
    curReq = "R6_R4";
    linearOrder = 1'b1;
    for (int s = 0; s < 4; s++) begin
      tick(1, 0, 0, {16'h0F0F, 2'(s)});
      for (int i = 0; i < 4; i++) tick(0, 0, 1, '0);
    end
    // R9: reload during burst with advance high; both strobes together
    curReq = "R9";
    tick(1, 0, 0, 18'h00001);
    tick(0, 0, 1, '0);
    tick(0, 1, 1, 18'h3FFFE);
    tick(0, 0, 1, '0);
    tick(1, 1, 1, 18'h15553);
    tick(0, 0, 1, '0);
    // R10: pipelined presentation in both orders
    curReq = "R10";
    pipeMode = 1'b1;
    tick(0, 0, 0, '0);
    tick(1, 0, 0, 18'h2AAA9);
    for (int i = 0; i < 5; i++) tick(0, 0, 1, '0);
    linearOrder = 1'b0;
    tick(0, 1, 1, 18'h0000E);
    for (int i = 0; i < 5; i++) tick(0, 0, 1, '0);
    // mixed random traffic across all controls
    curReq = "R4_R9_R10_mixed";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      linearOrder = r[8];
      pipeMode = r[9];
      tick(r[3:0] == 4'd0, r[3:0] == 4'd1, r[4] | r[5], AW'(r >> 12));
    end
    finishRun();
  end
endmodule